// File: doc/BRIEF.md
# Stereo pair transmit FIFO

This block buffers stereo audio words between a host and a serial audio transmitter. The host writes a left word and then a right word through a single write strobe with a left/right select. Only a complete left/right pair becomes a FIFO entry. Each entry holds both samples. The downstream serializer pulls one entry per read request and receives the left and right samples together, registered, one cycle after the request.

The FIFO holds a parameterised number of pairs (eight by default). It reports full and empty, and it raises a sticky overflow flag when a pair arrives while every entry is occupied. That pair is dropped and the stored entries are not touched. A word-size select masks each host word to its low 16 or 24 bits, or keeps all bits, as the word is written. Host words are right justified. Dropping the controller enable wipes every stored entry, both pointers, the half-written pair, the read output and the flags.

Top module: `stereo_pair_fifo`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, empty is 1, full is 0, ovf_flag is 0, rd_valid is 0 and rd_left/rd_right are zero.
- R2: A left write (wr_stb=1, wr_right=0) followed by a right write (wr_stb=1, wr_right=1) commits one entry. A later read returns the left word on rd_left and the right word on rd_right.
- R3: Entries leave in the order they were committed. The positions wrap from the last entry back to the first without loss, including when commits and reads overlap.
- R4: full is 1 exactly when DEPTH entries are held, empty is 1 exactly when none are held, and the two are never 1 together.
- R5: A pair completed while full is discarded, the stored entries are unchanged, and ovf_flag becomes 1 on the next cycle.
- R6: ovf_flag stays 1 until a cycle with ovf_clr=1. If a drop happens in the same cycle as ovf_clr, the flag stays 1.
- R7: While ctl_en is 0, all entries, both positions, the pending left word, ovf_flag, rd_valid and the read outputs are cleared to zero, and writes and reads are ignored. After re-enabling, only newly written pairs are read.
- R8: Each word is masked as it is written, according to word_mode: 0 keeps bits 15:0, 1 keeps bits 23:0, and 2 or 3 keeps all DATA_W bits. Bits above the kept width read back as zero.
- R9: A right write with no pending left word is ignored. A second left write before the right write replaces the pending left word.
- R10: A read request sets rd_valid on the next cycle only if the FIFO was not empty. Otherwise rd_valid is 0 and rd_left/rd_right keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Controller enable; 0 clears all state |
| wr_stb | input | 1 | Host word write strobe |
| wr_right | input | 1 | 0 = left word, 1 = right word |
| wr_data | input | DATA_W | Right-justified host word |
| word_mode | input | 2 | 0: 16-bit, 1: 24-bit, 2/3: full width |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_req | input | 1 | Serializer request for one pair |
| rd_valid | output | 1 | A pair was delivered on this cycle |
| rd_left | output | DATA_W | Left sample of the delivered pair |
| rd_right | output | DATA_W | Right sample of the delivered pair |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entries occupied |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The bench builds the FIFO with DEPTH=4 and DATA_W=32. With only four entries, every fill level, including overfill by two pairs and drain past empty, can be swept under each of the four word modes. Many wraps of the positions also fit within a short run. The full 32-bit width lets every mask boundary be seen, because the bench drives patterns with set upper bits and computes the masked values itself.

// File: rtl/stpf_pkg.sv
package stpf_pkg;

    typedef enum logic [1:0] {
        WM_16    = 2'd0,
        WM_24    = 2'd1,
        WM_FULL  = 2'd2,
        WM_FULL2 = 2'd3
    } word_mode_e;

    // Number of low bits kept for a given mode and word width.
    function automatic int unsigned kept_bits(word_mode_e m, int unsigned width);
        int unsigned k;
        case (m)
            WM_16:   k = 16;
            WM_24:   k = 24;
            default: k = width;
        endcase
        if (k > width) k = width;
        return k;
    endfunction

endpackage

// File: rtl/stpf_pack.sv
module stpf_pack #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic              wr_stb,
    input  logic              wr_right,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        word_mode,
    output logic              push,
    output logic [DATA_W-1:0] push_left,
    output logic [DATA_W-1:0] push_right
);
    import stpf_pkg::*;

    typedef struct packed {
        logic              pend_v;
        logic [DATA_W-1:0] pend_w;
    } pack_st_t;

    pack_st_t st_d, st_q;
    logic [DATA_W-1:0] masked;

    always_comb begin
        int unsigned keep;
        keep = kept_bits(word_mode_e'(word_mode), DATA_W);
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = wr_data[i] & (i < int'(keep));
        end

        push       = ctl_en & wr_stb & wr_right & st_q.pend_v;
        push_left  = st_q.pend_w;
        push_right = masked;

        st_d = st_q;
        if (!ctl_en) begin
            st_d = '0;
        end else if (wr_stb) begin
            if (!wr_right) begin
                st_d.pend_v = 1'b1;
                st_d.pend_w = masked;
            end else begin
                st_d.pend_v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/stpf_ctrl.sv
module stpf_ctrl #(
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_en,
    input  logic          push,
    input  logic          rd_req,
    input  logic          ovf_clr,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic          rd_en,
    output logic [AW-1:0] rd_idx,
    output logic          full,
    output logic          empty,
    output logic          ovf_flag
);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
        logic        ovf;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        full     = (st_q.wp[AW] != st_q.rp[AW]) && (st_q.wp[AW-1:0] == st_q.rp[AW-1:0]);
        empty    = (st_q.wp == st_q.rp);
        ovf_flag = st_q.ovf;
        wr_idx   = st_q.wp[AW-1:0];
        rd_idx   = st_q.rp[AW-1:0];
        wr_en    = ctl_en & push & ~full;
        rd_en    = ctl_en & rd_req & ~empty;

        st_d = st_q;
        if (!ctl_en) begin
            st_d = '0;
        end else begin
            st_d.wp  = st_q.wp + (AW+1)'(wr_en);
            st_d.rp  = st_q.rp + (AW+1)'(rd_en);
            st_d.ovf = (st_q.ovf & ~ovf_clr) | (push & full);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/stpf_store.sv
module stpf_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_left,
    input  logic [DATA_W-1:0] wr_right,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_idx,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_left,
    output logic [DATA_W-1:0] rd_right
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] lft;
        logic [DEPTH-1:0][DATA_W-1:0] rgt;
        logic [DATA_W-1:0]            out_l;
        logic [DATA_W-1:0]            out_r;
        logic                         vld;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!ctl_en) begin
            st_d = '0;
        end else begin
            if (wr_en) begin
                st_d.lft[wr_idx] = wr_left;
                st_d.rgt[wr_idx] = wr_right;
            end
            if (rd_en) begin
                st_d.out_l = st_q.lft[rd_idx];
                st_d.out_r = st_q.rgt[rd_idx];
                st_d.vld   = 1'b1;
            end
        end
        rd_valid = st_q.vld;
        rd_left  = st_q.out_l;
        rd_right = st_q.out_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/stereo_pair_fifo.sv
module stereo_pair_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic              wr_stb,
    input  logic              wr_right,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        word_mode,
    input  logic              ovf_clr,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_left,
    output logic [DATA_W-1:0] rd_right,
    output logic              full,
    output logic              empty,
    output logic              ovf_flag
);

    logic              pair_push;
    logic [DATA_W-1:0] pair_l, pair_r;
    logic              wr_en, rd_en;
    logic [AW-1:0]     wr_idx, rd_idx;

    stpf_pack #(.DATA_W(DATA_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_en     (ctl_en),
        .wr_stb     (wr_stb),
        .wr_right   (wr_right),
        .wr_data    (wr_data),
        .word_mode  (word_mode),
        .push       (pair_push),
        .push_left  (pair_l),
        .push_right (pair_r)
    );

    stpf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_en   (ctl_en),
        .push     (pair_push),
        .rd_req   (rd_req),
        .ovf_clr  (ovf_clr),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .full     (full),
        .empty    (empty),
        .ovf_flag (ovf_flag)
    );

    stpf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_en   (ctl_en),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_left  (pair_l),
        .wr_right (pair_r),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_left  (rd_left),
        .rd_right (rd_right)
    );

endmodule

// File: rtl/stpf_chk.sv
module stpf_chk (
    input logic clk,
    input logic rst_n,
    input logic ctl_en,
    input logic rd_req,
    input logic ovf_clr,
    input logic pair_push,
    input logic full,
    input logic empty,
    input logic ovf_flag,
    input logic rd_valid
);

    // R4: occupancy flags are exclusive
    a_r4_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R4: full can only appear after a pair was completed
    a_r4_full_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && !full && !pair_push) |=> !full);

    // R5: a full FIFO with no read stays full when a pair arrives
    a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && full && pair_push && !rd_req) |=> (full && ovf_flag));

    // R6: sticky overflow
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && ovf_flag && !ovf_clr) |=> ovf_flag);

    // R7: disable wipes flags and output
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (empty && !full && !ovf_flag && !rd_valid));

    // R10: no delivery from an empty FIFO
    a_r10_empty_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty) |=> !rd_valid);

endmodule

bind stereo_pair_fifo stpf_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_en    (ctl_en),
    .rd_req    (rd_req),
    .ovf_clr   (ovf_clr),
    .pair_push (pair_push),
    .full      (full),
    .empty     (empty),
    .ovf_flag  (ovf_flag),
    .rd_valid  (rd_valid)
);

// File: tb/stereo_pair_fifo_test.sv
module stereo_pair_fifo_test;

    localparam int D = 4;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_en = 1'b0;
    logic          wr_stb = 1'b0;
    logic          wr_right = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic [1:0]    word_mode = 2'd2;
    logic          ovf_clr = 1'b0;
    logic          rd_req = 1'b0;
    logic          rd_valid, full, empty, ovf_flag;
    logic [W-1:0]  rd_left, rd_right;

    always #10 clk = ~clk;

    stereo_pair_fifo #(.DEPTH(D), .DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .wr_stb(wr_stb),
        .wr_right(wr_right), .wr_data(wr_data), .word_mode(word_mode),
        .ovf_clr(ovf_clr), .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_left(rd_left), .rd_right(rd_right), .full(full),
        .empty(empty), .ovf_flag(ovf_flag)
    );

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic [W-1:0] ml [D];
    logic [W-1:0] mr [D];
    int head = 0, tail = 0, cnt = 0;
    bit pv = 0, ovf = 0, ev = 0;
    logic [W-1:0] pend = '0, eo_l = '0, eo_r = '0;

    function automatic logic [W-1:0] msk(input logic [W-1:0] d, input logic [1:0] m);
        if (m == 2'd0) return d & 32'h0000FFFF;
        if (m == 2'd1) return d & 32'h00FFFFFF;
        return d;
    endfunction

    function automatic logic [W-1:0] pat(input int k);
        return (32'(k) * 32'h9E3779B1) ^ 32'hC3A50000;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO check FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "full",     W'(full),     W'(cnt == D));
        check(tag, "empty",    W'(empty),    W'(cnt == 0));
        check(tag, "ovf_flag", W'(ovf_flag), W'(ovf));
        check(tag, "rd_valid", W'(rd_valid), W'(ev));
        check(tag, "rd_left",  rd_left,  eo_l);
        check(tag, "rd_right", rd_right, eo_r);
    endtask

    task automatic cyc(input string tag, input bit stb, input bit rgt,
                       input logic [W-1:0] d, input logic [1:0] md,
                       input bit rq, input bit clr, input bit en);
        bit pair, pop, push, drop;
        @(negedge clk);
        wr_stb = stb; wr_right = rgt; wr_data = d; word_mode = md;
        rd_req = rq; ovf_clr = clr; ctl_en = en;
        pair = en && stb && rgt && pv;
        if (!en) begin
            head = 0; tail = 0; cnt = 0; pv = 0; ovf = 0; ev = 0;
            pend = '0; eo_l = '0; eo_r = '0;
        end else begin
            pop  = rq && (cnt > 0);
            push = pair && (cnt < D);
            drop = pair && (cnt == D);
            if (pop) begin
                eo_l = ml[head]; eo_r = mr[head]; head = (head + 1) % D; ev = 1;
            end else ev = 0;
            if (push) begin
                ml[tail] = pend; mr[tail] = msk(d, md); tail = (tail + 1) % D;
            end
            cnt = cnt + int'(push) - int'(pop);
            ovf = (ovf && !clr) || drop;
            if (stb) begin
                if (!rgt) begin pend = msk(d, md); pv = 1; end
                else pv = 0;
            end
        end
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic put_pair(input string tag, input logic [W-1:0] l,
                            input logic [W-1:0] r, input logic [1:0] md);
        cyc(tag, 1, 0, l, md, 0, 0, 1);
        cyc(tag, 1, 1, r, md, 0, 0, 1);
    endtask

    task automatic idle(input string tag, input bit rq, input bit clr);
        cyc(tag, 0, 0, '0, 2'd2, rq, clr, 1);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FIFO check FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < D; i++) begin ml[i] = '0; mr[i] = '0; end
        // R1: reset state
        #3;
        compare("R1");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cyc("R1", 0, 0, '0, 2'd2, 0, 0, 1);

        // R2 R3 R4 R5 R8 R10: sweep fill levels under each mode
        for (int md = 0; md < 4; md++) begin
            for (int n = 1; n <= D + 2; n++) begin
                for (int k = 0; k < n; k++)
                    put_pair((n > D) ? "R5" : "R8", pat(md*97 + n*11 + k),
                             pat(md*97 + n*11 + k + 500), 2'(md));
                idle("R4", 0, 0);
                for (int k = 0; k <= n; k++)
                    idle((k == n) ? "R10" : "R2", 1, 0);
                idle("R10", 1, 0);
                idle("R6", 0, (n > D));
            end
        end

        // R6: clear and drop in the same cycle keeps the flag
        for (int k = 0; k < D; k++) put_pair("R4", pat(k + 900), pat(k + 950), 2'd2);
        cyc("R6", 1, 0, pat(7), 2'd2, 0, 0, 1);
        cyc("R6", 1, 1, pat(8), 2'd2, 0, 1, 1);
        idle("R6", 0, 0);
        idle("R6", 0, 1);
        idle("R6", 0, 0);
        for (int k = 0; k <= D; k++) idle("R5", 1, 0);

        // R3: overlapping commits and reads across many wraps
        for (int k = 0; k < 5 * D; k++) begin
            cyc("R3", 1, 0, pat(k + 2000), 2'(k % 4), (k % 3) == 0, 0, 1);
            cyc("R3", 1, 1, pat(k + 3000), 2'(k % 4), 1, 0, 1);
        end
        for (int k = 0; k <= D; k++) idle("R3", 1, 0);

        // R9: orphan right word, replaced left word
        cyc("R9", 1, 1, pat(4000), 2'd2, 0, 0, 1);
        idle("R9", 1, 0);
        cyc("R9", 1, 0, pat(4001), 2'd2, 0, 0, 1);
        cyc("R9", 1, 0, pat(4002), 2'd1, 0, 0, 1);
        cyc("R9", 1, 1, pat(4003), 2'd0, 0, 0, 1);
        cyc("R9", 1, 1, pat(4004), 2'd2, 0, 0, 1);
        idle("R9", 1, 0);
        idle("R9", 1, 0);

        // R7: disable wipes everything and blocks traffic
        for (int k = 0; k < D; k++) put_pair("R7", pat(k + 5000), pat(k + 5100), 2'd2);
        cyc("R7", 1, 0, pat(5200), 2'd2, 0, 0, 1);
        cyc("R7", 1, 1, pat(5201), 2'd2, 0, 0, 1);
        idle("R7", 1, 0);
        cyc("R7", 1, 0, pat(5300), 2'd2, 1, 0, 0);
        cyc("R7", 1, 1, pat(5301), 2'd2, 1, 0, 0);
        cyc("R7", 1, 1, pat(5302), 2'd2, 1, 0, 1);
        idle("R7", 1, 0);
        put_pair("R7", pat(5400), pat(5401), 2'd2);
        idle("R7", 1, 0);
        idle("R7", 1, 0);

        report();
        $finish;
    end

endmodule